// File: doc/BRIEF.md
# Receive FIFO Pause Watermark Controller

This block sits beside a receive FIFO and decides when the local transmitter should send an IEEE 802.3x PAUSE frame. It compares the FIFO fill level, given in bytes, with two programmable thresholds. Both thresholds are written in 8-byte granules. When the level rises above the upper threshold, the block asks for a PAUSE that carries a fixed quanta value. The FIFO size sets that quanta: it is the size times 4 times 8, divided by 512.

While the level stays high, a refresh timer makes the block ask again for the same PAUSE. The timer reload is four times the gap between the thresholds, counted in granules. Once the level falls below the lower threshold, the block asks for a zero-quanta PAUSE, which tells the link partner to resume.

Each request appears on a request/quanta pair. The pair stays held until the frame transmitter acknowledges it. If the upper threshold is programmed to zero, pause generation is switched off completely.

Top module: `wm_pause_ctrl`

## Requirements
- R1: After a synchronous reset, `pause_req` is 0, `pause_quanta` is 0 and the controller is not in the paused state.
- R2: When not paused, with `hwm_gran` nonzero and `fill_level` strictly greater than `hwm_gran*8`, the next cycle shows `pause_req`=1 with `pause_quanta` = FIFO_BYTES*4*8/512 (64 for 1024 bytes). A level equal to `hwm_gran*8` requests nothing.
- R3: While `hwm_gran` is 0, no request is made and any pending request is dropped. Zeroing it while paused leaves the paused state silently, without a zero-quanta request.
- R4: While paused, XOFF requests repeat every G+1 cycles after entry, where G = (hwm_gran-lwm_gran)*4 when hwm_gran > lwm_gran and G = 0 otherwise.
- R5: While paused, with `fill_level` strictly less than `lwm_gran*8`, the next cycle shows `pause_req`=1 with `pause_quanta`=0 and the controller leaves the paused state. A level equal to `lwm_gran*8` keeps it paused.
- R6: A request stays asserted, with unchanged quanta, until a cycle in which `pause_ack` is 1. It drops in the following cycle unless a new request arises.
- R7: A new request raised while an older one is pending, or in the cycle that acknowledges it, replaces the older one: `pause_req` stays 1 and `pause_quanta` takes the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_level | input | LVL_W | Receive FIFO occupancy in bytes |
| lwm_gran | input | WM_W | Release threshold in 8-byte granules |
| hwm_gran | input | WM_W | Assert threshold in 8-byte granules; 0 disables generation |
| pause_ack | input | 1 | Transmitter accepts the pending request |
| pause_req | output | 1 | Pending PAUSE request |
| pause_quanta | output | 16 | Quanta for the pending request (0 means resume) |

## Verification
The bench builds the block with FIFO_BYTES=1024, so LVL_W=11, WM_W=8 and the XOFF quanta is 64. With this size, thresholds of 10 and 20 granules give a refresh period of 41 cycles. A single run can then cover entry, one refresh and exit, each at an exact cycle. Equal thresholds give G=0 and back-to-back refreshes. This exercises the case where a new request replaces the one just acknowledged on every cycle.

// File: rtl/wm_pause_pkg.sv
package wm_pause_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_PAUSED = 1'b1
    } wm_state_e;

    localparam int QUANTA_W = 16;

    typedef struct packed {
        logic                valid;
        logic [QUANTA_W-1:0] quanta;
    } pause_ev_t;

    // quanta placed in an XOFF frame for a FIFO of the given byte size
    function automatic int unsigned xoff_quanta(input int unsigned fifo_bytes);
        return (fifo_bytes * 4 * 8) / 512;
    endfunction

endpackage

// File: rtl/wm_threshold.sv
module wm_threshold #(
    parameter int LVL_W = 11,
    parameter int WM_W  = 8
) (
    input  logic [LVL_W-1:0] fill_level,
    input  logic [WM_W-1:0]  lwm_gran,
    input  logic [WM_W-1:0]  hwm_gran,
    output logic             gen_en,
    output logic             above_hi,
    output logic             below_lo
);
    localparam int BW = WM_W + 3;
    localparam int CW = (LVL_W > BW) ? LVL_W : BW;

    logic [CW-1:0] lvl_x;
    logic [CW-1:0] hi_bytes;
    logic [CW-1:0] lo_bytes;

    always_comb begin
        lvl_x    = CW'(fill_level);
        hi_bytes = CW'({hwm_gran, 3'b000});
        lo_bytes = CW'({lwm_gran, 3'b000});
        gen_en   = (hwm_gran != '0);
        above_hi = (lvl_x > hi_bytes);
        below_lo = (lvl_x < lo_bytes);
    end
endmodule

// File: rtl/wm_refresh_timer.sv
module wm_refresh_timer #(
    parameter int WM_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            run,
    input  logic [WM_W-1:0] lwm_gran,
    input  logic [WM_W-1:0] hwm_gran,
    output logic            at_zero
);
    localparam int TW = WM_W + 2;

    logic [TW-1:0] gap;
    logic [TW-1:0] cnt_q;

    // (hwm - lwm) bytes * 4 / 8 == (hwm_gran - lwm_gran) * 4
    always_comb begin
        if (hwm_gran > lwm_gran)
            gap = TW'(hwm_gran - lwm_gran) << 2;
        else
            gap = '0;
    end

    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= gap;
        else if (run) begin
            if (at_zero)
                cnt_q <= gap;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wm_req_hold.sv
module wm_req_hold
    import wm_pause_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  pause_ev_t           ev,
    input  logic                drop,
    input  logic                ack,
    output logic                req,
    output logic [QUANTA_W-1:0] quanta
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req    <= 1'b0;
            quanta <= '0;
        end else if (drop) begin
            req    <= 1'b0;
            quanta <= '0;
        end else if (ev.valid) begin
            req    <= 1'b1;
            quanta <= ev.quanta;
        end else if (ack) begin
            req    <= 1'b0;
        end
    end
endmodule

// File: rtl/wm_pause_ctrl.sv
module wm_pause_ctrl
    import wm_pause_pkg::*;
#(
    parameter int FIFO_BYTES = 1024,
    parameter int LVL_W      = $clog2(FIFO_BYTES + 1),
    parameter int WM_W       = $clog2(FIFO_BYTES / 8 + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LVL_W-1:0]    fill_level,
    input  logic [WM_W-1:0]     lwm_gran,
    input  logic [WM_W-1:0]     hwm_gran,
    input  logic                pause_ack,
    output logic                pause_req,
    output logic [QUANTA_W-1:0] pause_quanta
);
    localparam logic [QUANTA_W-1:0] XOFF_Q = QUANTA_W'(xoff_quanta(FIFO_BYTES));

    wm_state_e state_q, state_d;
    pause_ev_t ev;
    logic      gen_en, above_hi, below_lo;
    logic      tmr_load, tmr_run, tmr_zero;
    logic      in_pause;

    wm_threshold #(.LVL_W(LVL_W), .WM_W(WM_W)) u_thr (
        .fill_level (fill_level),
        .lwm_gran   (lwm_gran),
        .hwm_gran   (hwm_gran),
        .gen_en     (gen_en),
        .above_hi   (above_hi),
        .below_lo   (below_lo)
    );

    wm_refresh_timer #(.WM_W(WM_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .run      (tmr_run),
        .lwm_gran (lwm_gran),
        .hwm_gran (hwm_gran),
        .at_zero  (tmr_zero)
    );

    always_comb begin
        state_d  = state_q;
        ev       = '0;
        tmr_load = 1'b0;
        tmr_run  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (gen_en && above_hi) begin
                    state_d  = ST_PAUSED;
                    ev       = '{valid: 1'b1, quanta: XOFF_Q};
                    tmr_load = 1'b1;
                end
            end
            ST_PAUSED: begin
                if (!gen_en) begin
                    state_d = ST_IDLE;
                end else if (below_lo) begin
                    state_d = ST_IDLE;
                    ev      = '{valid: 1'b1, quanta: '0};
                end else begin
                    tmr_run = 1'b1;
                    if (tmr_zero)
                        ev = '{valid: 1'b1, quanta: XOFF_Q};
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign in_pause = (state_q == ST_PAUSED);

    wm_req_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .drop   (!gen_en),
        .ack    (pause_ack),
        .req    (pause_req),
        .quanta (pause_quanta)
    );
endmodule

// File: rtl/wm_pause_ctrl_chk.sv
module wm_pause_ctrl_chk
    import wm_pause_pkg::*;
#(
    parameter int FIFO_BYTES = 1024,
    parameter int LVL_W      = 11,
    parameter int WM_W       = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [LVL_W-1:0]    fill_level,
    input logic [WM_W-1:0]     lwm_gran,
    input logic [WM_W-1:0]     hwm_gran,
    input logic                pause_ack,
    input logic                pause_req,
    input logic [QUANTA_W-1:0] pause_quanta,
    input logic                paused
);
    localparam logic [QUANTA_W-1:0] XQ = QUANTA_W'(xoff_quanta(FIFO_BYTES));

    p_xoff_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (!paused && hwm_gran != '0 && int'(fill_level) > int'(hwm_gran) * 8)
        |=> (pause_req && pause_quanta == XQ && paused));

    p_quanta_legal_r2: assert property (@(posedge clk) disable iff (rst)
        pause_req |-> (pause_quanta == '0 || pause_quanta == XQ));

    p_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        (hwm_gran == '0) |=> (!pause_req && !paused));

    p_xon_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (paused && hwm_gran != '0 && int'(fill_level) < int'(lwm_gran) * 8)
        |=> (pause_req && pause_quanta == '0 && !paused));

    p_held_r6: assert property (@(posedge clk) disable iff (rst)
        (pause_req && !pause_ack && hwm_gran != '0) |=> pause_req);
endmodule

bind wm_pause_ctrl wm_pause_ctrl_chk #(
    .FIFO_BYTES (FIFO_BYTES),
    .LVL_W      (LVL_W),
    .WM_W       (WM_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fill_level   (fill_level),
    .lwm_gran     (lwm_gran),
    .hwm_gran     (hwm_gran),
    .pause_ack    (pause_ack),
    .pause_req    (pause_req),
    .pause_quanta (pause_quanta),
    .paused       (in_pause)
);

// File: tb/wm_pause_ctrl_tb.sv
`timescale 1ns/1ps
module wm_pause_ctrl_tb;
    localparam int FB = 1024;
    localparam int LW = 11;
    localparam int WW = 8;
    localparam int XQ = 64;

    typedef struct {
        int    q;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [LW-1:0] fill_level = '0;
    logic [WW-1:0] lwm_gran = '0;
    logic [WW-1:0] hwm_gran = '0;
    logic          pause_ack;
    logic          pause_req;
    logic [15:0]   pause_quanta;

    logic auto_ack = 1'b0;
    logic mon_ack  = 1'b0;
    logic man_ack  = 1'b0;
    assign pause_ack = auto_ack ? mon_ack : man_ack;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    exp_t exp_q[$];
    int   times[$];

    always #2 clk = ~clk;

    wm_pause_ctrl #(.FIFO_BYTES(FB), .LVL_W(LW), .WM_W(WW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .fill_level   (fill_level),
        .lwm_gran     (lwm_gran),
        .hwm_gran     (hwm_gran),
        .pause_ack    (pause_ack),
        .pause_req    (pause_req),
        .pause_quanta (pause_quanta)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int q, input string tag);
        exp_t e;
        e.q   = q;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: each sampled request is one delivered item, acknowledged at once
    always @(negedge clk) begin
        if (!rst && auto_ack) begin
            if (pause_req) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "unexpected request (R3/R5)", int'(pause_quanta), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(int'(pause_quanta) == e.q, e.tag, int'(pause_quanta), e.q);
                end
                times.push_back(cyc);
                mon_ack <= 1'b1;
            end else begin
                mon_ack <= 1'b0;
            end
        end else begin
            mon_ack <= 1'b0;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(pause_req == 1'b0, "R1 req after reset", int'(pause_req), 0);
        chk(pause_quanta == 16'd0, "R1 quanta after reset", int'(pause_quanta), 0);

        // R3: generation disabled with hwm 0, level high
        auto_ack = 1'b1;
        hwm_gran = 8'd0; lwm_gran = 8'd10; fill_level = 11'd1000;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(pause_req == 1'b0, "R3 no request when disabled", int'(pause_req), 0);

        // R2 boundary: equal to hwm*8 requests nothing
        lwm_gran = 8'd10; hwm_gran = 8'd20; fill_level = 11'd160;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0 && pause_req == 1'b0, "R2 level equal hwm", int'(pause_req), 0);

        // R2 entry, R4 refresh after 41 cycles, R5 boundary and exit, R7 replace on ack
        times.delete();
        fill_level = 11'd161;
        push(XQ, "R2 xoff on entry");
        push(XQ, "R4 refresh xoff");
        push(0,  "R5 xon on exit");
        @(posedge clk);
        @(negedge clk);
        fill_level = 11'd80;
        repeat (41) @(posedge clk);
        @(negedge clk);
        fill_level = 11'd79;
        @(posedge clk);
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R4 items left after refresh run", exp_q.size(), 0);
        chk(times.size() == 3, "R4 item count", times.size(), 3);
        if (times.size() == 3) begin
            chk(times[1] - times[0] == 41, "R4 refresh period", times[1] - times[0], 41);
            chk(times[2] - times[1] == 1, "R7 xon replaces acked xoff", times[2] - times[1], 1);
        end
        chk(pause_req == 1'b0, "R6 released after ack", int'(pause_req), 0);

        // R4 zero gap: equal thresholds refresh every cycle
        times.delete();
        lwm_gran = 8'd15; hwm_gran = 8'd15; fill_level = 11'd121;
        push(XQ, "R2 xoff zero gap");
        push(XQ, "R4 refresh gap 0 a");
        push(XQ, "R4 refresh gap 0 b");
        push(0,  "R5 xon zero gap");
        @(posedge clk);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        fill_level = 11'd50;
        @(posedge clk);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R4 items left zero gap", exp_q.size(), 0);
        chk(times.size() == 4, "R4 zero gap count", times.size(), 4);
        for (int i = 1; i < times.size(); i++)
            chk(times[i] - times[i-1] == 1, "R4 zero gap spacing", times[i] - times[i-1], 1);

        // R3: zeroing hwm while paused leaves silently
        lwm_gran = 8'd10; hwm_gran = 8'd20; fill_level = 11'd300;
        push(XQ, "R2 xoff before disable");
        @(posedge clk);
        @(negedge clk);
        hwm_gran = 8'd0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        fill_level = 11'd0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        hwm_gran = 8'd20;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(pause_req == 1'b0 && exp_q.size() == 0, "R3 silent exit, no xon", int'(pause_req), 0);

        // R6 / R7 with manual acknowledge
        auto_ack = 1'b0; man_ack = 1'b0;
        @(negedge clk);
        fill_level = 11'd200;
        @(posedge clk);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(pause_req == 1'b1, "R6 req held without ack", int'(pause_req), 1);
        chk(pause_quanta == 16'(XQ), "R6 quanta held", int'(pause_quanta), XQ);
        fill_level = 11'd50;
        @(posedge clk);
        @(negedge clk);
        chk(pause_req == 1'b1, "R7 pending replaced req", int'(pause_req), 1);
        chk(pause_quanta == 16'd0, "R7 pending replaced quanta", int'(pause_quanta), 0);
        man_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        man_ack = 1'b0;
        chk(pause_req == 1'b0, "R6 drop after ack", int'(pause_req), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule